// File: doc/BRIEF.md
# Core Power State Sequencer

This controller walks a single processor core through five power states of increasing depth. From shallowest to deepest they are full-speed run, reduced-speed run, clock halted, doze and off. In doze the PLL is stopped and the second-level cache is partly flushed. In off the core supply is removed and both caches have been flushed and powered down. A policy agent asks for a target state. A wake event pulls a sleeping core back to a running state. The sequencer drives the core clock enable, the PLL enable, the supply enable, a high/low voltage select, the cache flush requests and a cache power-down request. It waits on request/acknowledge inputs from the regulator, the PLL and the cache flush engines.

Entry into a deeper state always passes through each shallower state in turn. No supply or PLL is turned off until the flush that guards it has been acknowledged. Waking from any sleeping state restores the supply first, then the PLL. The clock returns only after the PLL reports lock, and the core always comes back at reduced speed. Each wake is timed against a cycle budget chosen by the state being left, and an overrun raises a sticky flag.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset the current state is full-speed run (code 0). Clock, PLL and supply enables and the high voltage select are 1. All flush and power-down requests are 0. `busy` and `lat_viol` are 0.
- R2: State codes are 0 full-speed run, 1 reduced-speed run, 2 clock halted, 3 doze, 4 off. A request for a deeper state moves `cur_state` up by exactly one code at a time until the target is reached.
- R3: `core_clk_en` is 0 in states 2 to 4. `pll_en` is 0 in states 3 and 4. `vdd_on` is 0 and `cache_pwr_dn` is 1 only in state 4. `vsel_hi` is 1 only in state 0.
- R4: Going from state 2 to 3 raises `l1_flush_req` and `l2_flush_req` with `l2_flush_full`=0 (partial). Each request is held until its done input is 1. `pll_en` stays 1 until both dones are seen.
- R5: Going from state 3 to 4 raises `l2_flush_req` with `l2_flush_full`=1. `vdd_on` stays 1 until `l2_flush_done` is seen. `vdd_on` then falls on the same edge that `cache_pwr_dn` rises.
- R6: A wake from states 2 to 4 restores the supply first and waits for `vdd_good` if the supply was off. It then enables the PLL and waits for `pll_lock`. Only after that does it raise `core_clk_en`, landing in state 1.
- R7: A `wake` pulse while the core is in state 0 or 1 has no effect.
- R8: A wake is timed in cycles from the edge that starts it to the edge that restores the clock. If that count exceeds the budget of the state left (2 for state 2, 12 for state 3, 40 for state 4), `lat_viol` goes to 1. `lat_viol` stays 1 until the next wake starts, which clears it.
- R9: A request that arrives while a transition is in progress is held. The transition in progress completes first, and the held target is acted on afterwards.
- R10: A request whose `req_state` is above 4 is ignored.
- R11: A request for state 0 from state 1 raises `vsel_hi` and enters state 0 in one step. From a sleeping state this happens after the wake lands in state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Target request strobe |
| req_state | input | 3 | Requested target state code |
| wake | input | 1 | Wake event |
| l1_flush_done | input | 1 | First-level cache flush finished |
| l2_flush_done | input | 1 | Second-level cache flush finished |
| vdd_good | input | 1 | Core supply is up |
| pll_lock | input | 1 | PLL is locked |
| core_clk_en | output | 1 | Core clock enable |
| pll_en | output | 1 | PLL enable |
| vdd_on | output | 1 | Core supply enable |
| vsel_hi | output | 1 | High voltage/frequency select |
| cache_pwr_dn | output | 1 | Cache arrays power-down request |
| l1_flush_req | output | 1 | First-level cache flush request |
| l2_flush_req | output | 1 | Second-level cache flush request |
| l2_flush_full | output | 1 | Second-level flush depth: 1 full, 0 partial |
| cur_state | output | 3 | Current state code |
| busy | output | 1 | Transition in progress or target not yet reached |
| lat_viol | output | 1 | Sticky wake latency overrun |

## Verification
Every cycle, the assertions check the single-step descent and the output values each state forces. They also check that the PLL and supply stay up until their flush is acknowledged, that flush requests hold until done, and the wake order of supply, then PLL, then lock, then clock. Only the bench scenarios can show the full sequence of visited states, the deferral of a request made mid-flush, and that wake pulses in run states and out-of-range requests are ignored. The same is true of the latency flag, which is set or cleared depending on how long the bench's regulator and PLL models take to respond against each state's budget.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int unsigned STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        PS_FAST = 3'd0,
        PS_SLOW = 3'd1,
        PS_HALT = 3'd2,
        PS_DOZE = 3'd3,
        PS_OFF  = 3'd4
    } pstate_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FLUSH,
        PH_VDD,
        PH_PLL
    } phase_e;

    typedef struct packed {
        pstate_e cur;
        pstate_e nxt;
        phase_e  ph;
        logic    clk_en;
        logic    pll_en;
        logic    vdd_on;
        logic    vsel_hi;
        logic    cache_pd;
        logic    l1_req;
        logic    l2_req;
        logic    l2_full;
    } ctl_t;

endpackage

// File: rtl/pwr_seq_target.sv
module pwr_seq_target
    import pwr_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [STATE_W-1:0] req_state,
    input  logic               wake,
    output pstate_e            tgt
);

    pstate_e tgt_d, tgt_q;

    // A wake only matters while the held goal is a sleeping state;
    // an explicit in-range request overrides it.
    always_comb begin
        tgt_d = tgt_q;
        if (wake && (tgt_q >= PS_HALT)) begin
            tgt_d = PS_SLOW;
        end
        if (req_valid && (req_state <= PS_OFF)) begin
            tgt_d = pstate_e'(req_state);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q <= PS_FAST;
        end else begin
            tgt_q <= tgt_d;
        end
    end

    assign tgt = tgt_q;

endmodule

// File: rtl/pwr_seq_latency.sv
module pwr_seq_latency
    import pwr_seq_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned BUDGET_HALT = 2,
    parameter int unsigned BUDGET_DOZE = 12,
    parameter int unsigned BUDGET_OFF  = 40
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  pstate_e from_state,
    input  logic    waiting,
    output logic    viol
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             viol;
    } lat_t;

    lat_t d, q;

    always_comb begin
        d = q;
        if (start) begin
            d.cnt  = '0;
            d.viol = 1'b0;
            case (from_state)
                PS_HALT: d.lim = CNT_W'(BUDGET_HALT);
                PS_DOZE: d.lim = CNT_W'(BUDGET_DOZE);
                default: d.lim = CNT_W'(BUDGET_OFF);
            endcase
        end else if (waiting) begin
            if (q.cnt != CNT_MAX) begin
                d.cnt = q.cnt + 1'b1;
            end
            // this edge closes cycle cnt+1 of the wake
            if (q.cnt >= q.lim) begin
                d.viol = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign viol = q.viol;

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned BUDGET_HALT = 2,
    parameter int unsigned BUDGET_DOZE = 12,
    parameter int unsigned BUDGET_OFF  = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [STATE_W-1:0] req_state,
    input  logic               wake,
    input  logic               l1_flush_done,
    input  logic               l2_flush_done,
    input  logic               vdd_good,
    input  logic               pll_lock,
    output logic               core_clk_en,
    output logic               pll_en,
    output logic               vdd_on,
    output logic               vsel_hi,
    output logic               cache_pwr_dn,
    output logic               l1_flush_req,
    output logic               l2_flush_req,
    output logic               l2_flush_full,
    output logic [STATE_W-1:0] cur_state,
    output logic               busy,
    output logic               lat_viol
);

    localparam ctl_t CTL_RESET = '{
        cur:      PS_FAST,
        nxt:      PS_FAST,
        ph:       PH_IDLE,
        clk_en:   1'b1,
        pll_en:   1'b1,
        vdd_on:   1'b1,
        vsel_hi:  1'b1,
        cache_pd: 1'b0,
        l1_req:   1'b0,
        l2_req:   1'b0,
        l2_full:  1'b0
    };

    pstate_e tgt;
    ctl_t    d, q;
    logic    wake_start;
    logic    wake_wait;

    pwr_seq_target u_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_state (req_state),
        .wake      (wake),
        .tgt       (tgt)
    );

    assign wake_wait = (q.ph == PH_VDD) || (q.ph == PH_PLL);

    pwr_seq_latency #(
        .CNT_W       (CNT_W),
        .BUDGET_HALT (BUDGET_HALT),
        .BUDGET_DOZE (BUDGET_DOZE),
        .BUDGET_OFF  (BUDGET_OFF)
    ) u_latency (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (wake_start),
        .from_state (q.cur),
        .waiting    (wake_wait),
        .viol       (lat_viol)
    );

    always_comb begin
        d          = q;
        wake_start = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (tgt > q.cur) begin
                    // descend exactly one level
                    case (q.cur)
                        PS_FAST: begin
                            d.vsel_hi = 1'b0;
                            d.cur     = PS_SLOW;
                        end
                        PS_SLOW: begin
                            d.clk_en = 1'b0;
                            d.cur    = PS_HALT;
                        end
                        PS_HALT: begin
                            d.l1_req  = 1'b1;
                            d.l2_req  = 1'b1;
                            d.l2_full = 1'b0;
                            d.nxt     = PS_DOZE;
                            d.ph      = PH_FLUSH;
                        end
                        PS_DOZE: begin
                            d.l2_req  = 1'b1;
                            d.l2_full = 1'b1;
                            d.nxt     = PS_OFF;
                            d.ph      = PH_FLUSH;
                        end
                        default: ;
                    endcase
                end else if (tgt < q.cur) begin
                    if (q.cur == PS_SLOW) begin
                        d.vsel_hi = 1'b1;
                        d.cur     = PS_FAST;
                    end else begin
                        wake_start = 1'b1;
                        if (!q.vdd_on) begin
                            d.vdd_on   = 1'b1;
                            d.cache_pd = 1'b0;
                            d.ph       = PH_VDD;
                        end else begin
                            d.pll_en = 1'b1;
                            d.ph     = PH_PLL;
                        end
                    end
                end
            end
            PH_FLUSH: begin
                if (l2_flush_done && (l1_flush_done || !q.l1_req)) begin
                    d.l1_req = 1'b0;
                    d.l2_req = 1'b0;
                    d.ph     = PH_IDLE;
                    d.cur    = q.nxt;
                    if (q.nxt == PS_DOZE) begin
                        d.pll_en = 1'b0;
                    end else begin
                        d.cache_pd = 1'b1;
                        d.vdd_on   = 1'b0;
                    end
                end
            end
            PH_VDD: begin
                if (vdd_good) begin
                    d.pll_en = 1'b1;
                    d.ph     = PH_PLL;
                end
            end
            PH_PLL: begin
                if (pll_lock) begin
                    d.clk_en = 1'b1;
                    d.cur    = PS_SLOW;
                    d.ph     = PH_IDLE;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTL_RESET;
        end else begin
            q <= d;
        end
    end

    assign core_clk_en   = q.clk_en;
    assign pll_en        = q.pll_en;
    assign vdd_on        = q.vdd_on;
    assign vsel_hi       = q.vsel_hi;
    assign cache_pwr_dn  = q.cache_pd;
    assign l1_flush_req  = q.l1_req;
    assign l2_flush_req  = q.l2_req;
    assign l2_flush_full = q.l2_full;
    assign cur_state     = q.cur;
    assign busy          = (q.ph != PH_IDLE) || (tgt != q.cur);

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cur_state,
    input logic       core_clk_en,
    input logic       pll_en,
    input logic       pll_lock,
    input logic       vdd_on,
    input logic       l1_flush_req,
    input logic       l1_flush_done,
    input logic       l2_flush_req,
    input logic       l2_flush_done,
    input logic       l2_flush_full
);

    a_r2_one_step_deeper: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state > $past(cur_state)) |-> (cur_state == $past(cur_state) + 3'd1));

    a_r3_clock_off_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state >= 3'd2) |-> !core_clk_en);

    a_r3_supply_on_unless_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state != 3'd4) |-> vdd_on);

    a_r4_pll_waits_for_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |-> $past(l1_flush_done && l2_flush_done));

    a_r4_l1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_flush_req && !l1_flush_done) |=> l1_flush_req);

    a_r4_l2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_flush_req && !l2_flush_done) |=> l2_flush_req);

    a_r5_supply_waits_for_full_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vdd_on) |-> $past(l2_flush_done && l2_flush_full));

    a_r6_pll_after_supply: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> vdd_on);

    a_r6_clock_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> $past(pll_lock));

    a_r6_wake_lands_slow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> (cur_state == 3'd1));

endmodule

bind core_pwr_seq pwr_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cur_state     (cur_state),
    .core_clk_en   (core_clk_en),
    .pll_en        (pll_en),
    .pll_lock      (pll_lock),
    .vdd_on        (vdd_on),
    .l1_flush_req  (l1_flush_req),
    .l1_flush_done (l1_flush_done),
    .l2_flush_req  (l2_flush_req),
    .l2_flush_done (l2_flush_done),
    .l2_flush_full (l2_flush_full)
);

// File: tb/core_pwr_seq_tb.sv
module core_pwr_seq_tb;

    localparam logic [2:0] S_FAST = 3'd0;
    localparam logic [2:0] S_SLOW = 3'd1;
    localparam logic [2:0] S_HALT = 3'd2;
    localparam logic [2:0] S_DOZE = 3'd3;
    localparam logic [2:0] S_OFF  = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_state = 3'd0;
    logic       wake = 1'b0;
    logic       l1_flush_done, l2_flush_done, vdd_good, pll_lock;
    logic       core_clk_en, pll_en, vdd_on, vsel_hi, cache_pwr_dn;
    logic       l1_flush_req, l2_flush_req, l2_flush_full;
    logic [2:0] cur_state;
    logic       busy, lat_viol;

    int n_checks = 0;
    int n_fail   = 0;
    int l1_dly = 2, l2_dly = 2, vdd_dly = 3, pll_dly = 3;
    int l1_cnt = 0, l2_cnt = 0, vdd_cnt = 0, pll_cnt = 0;
    bit finished = 1'b0;

    logic [2:0] exp_q[$];
    logic [2:0] last_state = 3'd0;

    always #10 clk = ~clk;

    core_pwr_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_state     (req_state),
        .wake          (wake),
        .l1_flush_done (l1_flush_done),
        .l2_flush_done (l2_flush_done),
        .vdd_good      (vdd_good),
        .pll_lock      (pll_lock),
        .core_clk_en   (core_clk_en),
        .pll_en        (pll_en),
        .vdd_on        (vdd_on),
        .vsel_hi       (vsel_hi),
        .cache_pwr_dn  (cache_pwr_dn),
        .l1_flush_req  (l1_flush_req),
        .l2_flush_req  (l2_flush_req),
        .l2_flush_full (l2_flush_full),
        .cur_state     (cur_state),
        .busy          (busy),
        .lat_viol      (lat_viol)
    );

    // responder models for caches, regulator and PLL
    always @(posedge clk) begin
        l1_cnt  <= l1_flush_req ? l1_cnt + 1 : 0;
        l2_cnt  <= l2_flush_req ? l2_cnt + 1 : 0;
        vdd_cnt <= vdd_on ? vdd_cnt + 1 : 0;
        pll_cnt <= pll_en ? pll_cnt + 1 : 0;
    end
    assign l1_flush_done = l1_flush_req && (l1_cnt >= l1_dly);
    assign l2_flush_done = l2_flush_req && (l2_cnt >= l2_dly);
    assign vdd_good      = vdd_on && (vdd_cnt >= vdd_dly);
    assign pll_lock      = pll_en && (pll_cnt >= pll_dly);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every change of state must match the next expected one
    always @(negedge clk) begin
        if (rst_n && !finished && (cur_state != last_state)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected state change", int'(cur_state), int'(last_state));
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                check(cur_state == e, "R2 state sequence", int'(cur_state), int'(e));
            end
            last_state = cur_state;
        end
    end

    task automatic push(input logic [2:0] s);
        exp_q.push_back(s);
    endtask

    task automatic request(input logic [2:0] s);
        @(negedge clk);
        req_valid = 1'b1;
        req_state = s;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wake_pulse();
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_for_high(ref logic sig);
        int n = 0;
        while (!sig && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int wd = 0;
        while (!finished && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!finished) begin
            check(1'b0, "watchdog expired", wd, 0);
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cur_state == S_FAST, "R1 reset state", int'(cur_state), 0);
        check(core_clk_en && pll_en && vdd_on && vsel_hi, "R1 enables on",
              int'({core_clk_en, pll_en, vdd_on, vsel_hi}), 15);
        check(!cache_pwr_dn && !l1_flush_req && !l2_flush_req && !busy && !lat_viol,
              "R1 requests clear", int'({cache_pwr_dn, l1_flush_req, l2_flush_req, busy, lat_viol}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2/R3 fast to slow
        push(S_SLOW);
        request(S_SLOW);
        wait_idle();
        check(!vsel_hi && core_clk_en, "R3 slow outputs", int'({vsel_hi, core_clk_en}), 1);

        // R4 descent into doze with slow L1 flush
        l1_dly = 6;
        push(S_HALT); push(S_DOZE);
        request(S_DOZE);
        wait_for_high(l1_flush_req);
        check(l2_flush_req && !l2_flush_full, "R4 partial L2 flush issued",
              int'({l2_flush_req, l2_flush_full}), 2);
        check(pll_en && !core_clk_en, "R4 PLL kept during flush", int'({pll_en, core_clk_en}), 2);
        repeat (3) @(negedge clk);
        check(pll_en && l1_flush_req, "R4 request held until done", int'({pll_en, l1_flush_req}), 3);
        wait_idle();
        check(cur_state == S_DOZE && !pll_en && !core_clk_en && vdd_on, "R3 doze outputs",
              int'({pll_en, core_clk_en, vdd_on}), 1);

        // R6/R8 wake from doze within budget
        push(S_SLOW);
        wake_pulse();
        wait_idle();
        check(cur_state == S_SLOW && core_clk_en, "R6 wake from doze", int'(cur_state), 1);
        check(!lat_viol, "R8 doze wake within budget", int'(lat_viol), 0);

        // R5 descent to off
        l2_dly = 5;
        push(S_HALT); push(S_DOZE); push(S_OFF);
        request(S_OFF);
        @(negedge clk);
        while (!(l2_flush_req && l2_flush_full)) @(negedge clk);
        check(vdd_on && !cache_pwr_dn, "R5 supply kept during full flush",
              int'({vdd_on, cache_pwr_dn}), 2);
        wait_idle();
        check(!vdd_on && cache_pwr_dn && !pll_en, "R5 off outputs",
              int'({vdd_on, cache_pwr_dn, pll_en}), 2);

        // R6 wake order from off
        push(S_SLOW);
        wake_pulse();
        wait_for_high(vdd_on);
        check(!pll_en && !core_clk_en, "R6 supply first", int'({pll_en, core_clk_en}), 0);
        wait_for_high(pll_en);
        check(vdd_good && !core_clk_en, "R6 PLL after supply good", int'({vdd_good, core_clk_en}), 2);
        wait_for_high(core_clk_en);
        check(cur_state == S_SLOW, "R6 lands in slow run", int'(cur_state), 1);
        check(!lat_viol, "R8 off wake within budget", int'(lat_viol), 0);

        // R9/R11 request held during a flush
        l2_dly = 10;
        push(S_HALT); push(S_DOZE); push(S_OFF); push(S_SLOW); push(S_FAST);
        request(S_OFF);
        @(negedge clk);
        while (!(l2_flush_req && l2_flush_full)) @(negedge clk);
        request(S_FAST);
        check(busy && cur_state == S_DOZE, "R9 request held mid-flush", int'(cur_state), 3);
        wait_idle();
        check(cur_state == S_FAST && vsel_hi, "R11 reaches fast after wake", int'(cur_state), 0);
        l2_dly = 2;

        // R7 wake in run state ignored
        wake_pulse();
        repeat (3) @(negedge clk);
        check(cur_state == S_FAST && !busy, "R7 wake ignored in run", int'(cur_state), 0);

        // R10 out-of-range requests ignored
        request(3'd5);
        repeat (2) @(negedge clk);
        check(cur_state == S_FAST && !busy, "R10 code 5 ignored", int'(cur_state), 0);
        request(3'd7);
        repeat (2) @(negedge clk);
        check(cur_state == S_FAST && !busy, "R10 code 7 ignored", int'(cur_state), 0);

        // R8 slow PLL from off overruns budget
        push(S_SLOW); push(S_HALT); push(S_DOZE); push(S_OFF);
        request(S_OFF);
        wait_idle();
        pll_dly = 60;
        push(S_SLOW);
        wake_pulse();
        wait_idle();
        check(lat_viol, "R8 off wake overrun flagged", int'(lat_viol), 1);

        // R8 flag cleared by next in-budget wake
        pll_dly = 3;
        push(S_HALT); push(S_DOZE);
        request(S_DOZE);
        wait_idle();
        check(lat_viol, "R8 flag sticky until next wake", int'(lat_viol), 1);
        push(S_SLOW);
        wake_pulse();
        wait_idle();
        check(!lat_viol, "R8 flag cleared by good wake", int'(lat_viol), 0);

        // R8 doze budget overrun
        pll_dly = 20;
        push(S_HALT); push(S_DOZE);
        request(S_DOZE);
        wait_idle();
        push(S_SLOW);
        wake_pulse();
        wait_idle();
        check(lat_viol, "R8 doze wake overrun flagged", int'(lat_viol), 1);

        // R8 halt wake fits its budget
        pll_dly = 3;
        push(S_HALT);
        request(S_HALT);
        wait_idle();
        push(S_SLOW);
        wake_pulse();
        wait_idle();
        check(!lat_viol && cur_state == S_SLOW, "R8 halt wake within budget", int'(lat_viol), 0);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected states seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule